// File: doc/BRIEF.md
# Lead-Lag Bit Clock Recovery Loop

This block recovers a bit-rate sampling strobe from a serial data stream that is sampled by a much faster system clock. A free-running period counter acts as a digitally controlled oscillator whose nominal length is one symbol, `PERIOD` system clocks. Every transition of the incoming data, in either direction, becomes a one-cycle pulse. That pulse freezes a comparison between the counter's value and the half-symbol point. A transition that arrives before the half point means the local phase runs ahead, so the following counter period is stretched by `STEP` cycles. A transition after the half point means the local phase trails, so that period is shrunk by `STEP`. After one adjusted period the length falls back to `PERIOD`. No loop filter sits between the phase detector and the counter, so every transition is free to steer the phase.

A mode pin picks where the strobe lands inside the symbol. With square-wave data the strobe sits on the recovered edge, at count zero. With pulse-shaped data it is moved half a symbol later, at count `PERIOD/2`, so that the sample lands at mid-symbol. On each strobe the synchronised data level is captured and presented as a bit with a one-cycle valid. The recovered stream cannot be stalled: the output carries valid without ready, and a consumer must take each bit in the cycle its valid is high.

Top module: `bitsync_dpll`

## Requirements
- R1: With no data transitions, `clk_stb` pulses high for exactly one cycle every `PERIOD` cycles, in either mode.
- R2: A transition seen while the counter is below `PERIOD/2` makes the next counter period `PERIOD+STEP` cycles long.
- R3: A transition seen while the counter is above `PERIOD/2` makes the next counter period `PERIOD-STEP` cycles long.
- R4: A transition seen while the counter equals exactly `PERIOD/2` leaves the next period at `PERIOD`.
- R5: A correction never changes the period in progress, and it lasts for one period only. The period after it is `PERIOD` again unless a new transition intervenes.
- R6: `data_in` passes through a two-stage synchroniser before edge detection. A level change applied `j` cycles after a mode-1 strobe is therefore compared against counter value `j+2`.
- R7: With `mode_edge`=1 the strobe marks counter value 0, which is the period boundary. With `mode_edge`=0 the strobe comes `PERIOD/2` cycles later, at counter value `PERIOD/2`.
- R8: Reset clears the counter, loads `PERIOD` and holds `clk_stb` and `bit_vld` low. The first strobe after reset release follows the `PERIOD`th clock edge in mode 1 and the `PERIOD+PERIOD/2`th clock edge in mode 0.
- R9: `bit_vld` is high exactly in the cycles where `clk_stb` is high, and `bit_out` then holds the synchronised data level sampled at that strobe.
- R10: A transition seen in the last cycle of a period applies its correction to the period that begins immediately afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 1 | Serial received data, asynchronous to clk |
| mode_edge | input | 1 | 1: strobe on recovered edges; 0: strobe at mid-symbol |
| clk_stb | output | 1 | Recovered bit-clock strobe, one cycle wide |
| bit_out | output | 1 | Data level captured at the strobe |
| bit_vld | output | 1 | Valid for bit_out, no back-pressure |

## Verification
Assertions watch, on every cycle, that the corrected length picked on a transition matches the side of the half point on which that transition fell. They also check that the active period length changes only at a period boundary, that the pending length returns to nominal after each boundary, and that strobes are single-cycle and paired with valid. Only the bench's scenarios show the end-to-end timing: measured strobe spacings for transitions placed at chosen counter positions, the two-cycle synchroniser delay, the half-symbol shift of mode 0, and the first-strobe delay after reset in each mode.

// File: rtl/bitsync_pkg.sv
package bitsync_pkg;
  // Outcome of one phase comparison
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_EARLY  = 2'd1,
    PH_LATE   = 2'd2,
    PH_CENTRE = 2'd3
  } phase_e;
endpackage

// File: rtl/bitsync_edge.sv
module bitsync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dsync,
  output logic edge_p
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sr;
  logic         prev;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '0;
        else        sr <= din;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '0;
        else        sr <= {sr[MSB-1:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= sr[MSB];

  assign dsync  = sr[MSB];
  assign edge_p = sr[MSB] ^ prev;
endmodule

// File: rtl/bitsync_phdet.sv
module bitsync_phdet
  import bitsync_pkg::*;
#(
  parameter int PERIOD = 16,
  parameter int STEP   = 1,
  parameter int CW     = 5
) (
  input  logic          edge_p,
  input  logic [CW-1:0] cnt,
  output phase_e        ph,
  output logic [CW-1:0] corr_len
);
  localparam logic [CW-1:0] HALF_C  = CW'(PERIOD / 2);
  localparam logic [CW-1:0] LONG_C  = CW'(PERIOD + STEP);
  localparam logic [CW-1:0] SHORT_C = CW'(PERIOD - STEP);
  localparam logic [CW-1:0] NOM_C   = CW'(PERIOD);

  always_comb begin
    if (!edge_p)            ph = PH_IDLE;
    else if (cnt < HALF_C)  ph = PH_EARLY;
    else if (cnt > HALF_C)  ph = PH_LATE;
    else                    ph = PH_CENTRE;

    unique case (ph)
      PH_EARLY: corr_len = LONG_C;
      PH_LATE:  corr_len = SHORT_C;
      default:  corr_len = NOM_C;
    endcase
  end
endmodule

// File: rtl/bitsync_dco.sv
module bitsync_dco
  import bitsync_pkg::*;
#(
  parameter int PERIOD = 16,
  parameter int CW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        ph,
  input  logic [CW-1:0] corr_len,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cur_len,
  output logic [CW-1:0] pend_len,
  output logic          wrap,
  output logic          armed
);
  localparam logic [CW-1:0] NOM_C = CW'(PERIOD);

  logic hit;
  assign hit  = (ph != PH_IDLE);
  assign wrap = (cnt == cur_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      cur_len  <= NOM_C;
      pend_len <= NOM_C;
      armed    <= 1'b0;
    end else if (wrap) begin
      cnt      <= '0;
      cur_len  <= hit ? corr_len : pend_len;
      pend_len <= NOM_C;
      armed    <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
      if (hit) pend_len <= corr_len;
    end
  end
endmodule

// File: rtl/bitsync_dpll.sv
module bitsync_dpll
  import bitsync_pkg::*;
#(
  parameter int PERIOD = 16,   // symbol length in clk cycles, > 2*STEP+2
  parameter int STEP   = 1     // one-shot period correction
) (
  input  logic clk,
  input  logic rst_n,
  input  logic data_in,
  input  logic mode_edge,
  output logic clk_stb,
  output logic bit_out,
  output logic bit_vld
);
  localparam int CW = $clog2(PERIOD + STEP + 1);
  localparam logic [CW-1:0] MID_PRE = CW'(PERIOD / 2 - 1);

  logic          dsync, edge_p, wrap, armed, fire;
  logic [CW-1:0] cnt, cur_len, pend_len, corr_len;
  phase_e        ph;

  bitsync_edge #(.SYNC_STAGES(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .din(data_in),
    .dsync(dsync), .edge_p(edge_p)
  );

  bitsync_phdet #(.PERIOD(PERIOD), .STEP(STEP), .CW(CW)) u_phdet (
    .edge_p(edge_p), .cnt(cnt), .ph(ph), .corr_len(corr_len)
  );

  bitsync_dco #(.PERIOD(PERIOD), .CW(CW)) u_dco (
    .clk(clk), .rst_n(rst_n), .ph(ph), .corr_len(corr_len),
    .cnt(cnt), .cur_len(cur_len), .pend_len(pend_len),
    .wrap(wrap), .armed(armed)
  );

  // Edge mode fires on the boundary; mid mode fires half a symbol on,
  // only once a full period has elapsed since reset.
  assign fire = mode_edge ? wrap : (armed && cnt == MID_PRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_stb <= 1'b0;
      bit_vld <= 1'b0;
      bit_out <= 1'b0;
    end else begin
      clk_stb <= fire;
      bit_vld <= fire;
      if (fire) bit_out <= dsync;
    end
  end
endmodule

// File: rtl/bitsync_dpll_chk.sv
module bitsync_dpll_chk #(
  parameter int PERIOD = 16,
  parameter int STEP   = 1,
  parameter int CW     = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          edge_p,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cur_len,
  input logic [CW-1:0] pend_len,
  input logic          wrap,
  input logic          armed,
  input logic          stb,
  input logic          vld
);
  localparam logic [CW-1:0] HALF_C  = CW'(PERIOD / 2);
  localparam logic [CW-1:0] LONG_C  = CW'(PERIOD + STEP);
  localparam logic [CW-1:0] SHORT_C = CW'(PERIOD - STEP);
  localparam logic [CW-1:0] NOM_C   = CW'(PERIOD);

  // R1
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);
  // R2
  early_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_p && cnt < HALF_C) |=> pend_len == LONG_C);
  // R3
  late_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_p && cnt > HALF_C && !wrap) |=> pend_len == SHORT_C);
  // R4
  centre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_p && cnt == HALF_C) |=> pend_len == NOM_C);
  // R5
  len_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(cur_len));
  // R5
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> pend_len == NOM_C);
  // R8
  armed_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> armed);
  // R9
  valid_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb == vld);
  // R10
  boundary_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_p && wrap) |=> cur_len == SHORT_C);
endmodule

bind bitsync_dpll bitsync_dpll_chk #(.PERIOD(PERIOD), .STEP(STEP), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_p(edge_p), .cnt(cnt),
  .cur_len(cur_len), .pend_len(pend_len), .wrap(wrap), .armed(armed),
  .stb(clk_stb), .vld(bit_vld)
);

// File: tb/test_bitsync_dpll.sv
module test_bitsync_dpll;
  localparam int PERIOD = 16;
  localparam int STEP   = 1;
  localparam int HALF   = PERIOD / 2;

  logic clk = 1'b0, rst_n = 1'b0, data_in = 1'b0, mode_edge = 1'b1;
  logic clk_stb, bit_out, bit_vld;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  bitsync_dpll #(.PERIOD(PERIOD), .STEP(STEP)) i_bitsync_dpll (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .mode_edge(mode_edge),
    .clk_stb(clk_stb), .bit_out(bit_out), .bit_vld(bit_vld)
  );

  // {cycles after strobe before toggling, expected length of next period}
  localparam int NV = 6;
  localparam int VEC [NV][2] = '{
    '{0, PERIOD+STEP}, '{5, PERIOD+STEP}, '{6, PERIOD},
    '{7, PERIOD-STEP}, '{10, PERIOD-STEP}, '{13, PERIOD-STEP}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Count clock edges until a strobe is observed (sampled at negedge)
  task automatic wait_stb(output int n);
    n = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end while (!clk_stb && n < 200);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n, n0, n1, n2;
    // R8: outputs held low in reset
    repeat (3) @(negedge clk);
    check(clk_stb == 1'b0 && bit_vld == 1'b0, "R8 reset outputs", int'(clk_stb), 0);
    rst_n = 1'b1;
    wait_stb(n);
    check(n == PERIOD, "R8 first strobe mode 1", n, PERIOD);
    // R9 valid paired, single cycle
    check(bit_vld == 1'b1, "R9 valid with strobe", int'(bit_vld), 1);
    @(negedge clk);
    check(clk_stb == 1'b0 && bit_vld == 1'b0, "R1 R9 single-cycle strobe", int'(clk_stb), 0);
    wait_stb(n);
    check(n == PERIOD - 1, "R1 idle spacing", n + 1, PERIOD);
    wait_stb(n);
    check(n == PERIOD, "R1 idle spacing", n, PERIOD);

    // Table walk: toggle data at a chosen counter position (R6: j+2)
    for (int v = 0; v < NV; v++) begin
      int j, e;
      string tag;
      j = VEC[v][0];
      e = VEC[v][1];
      tag = (j == PERIOD - 3) ? "R10" : (e > PERIOD) ? "R2" : (e < PERIOD) ? "R3" : "R4";
      wait_stb(n);
      repeat (j) @(negedge clk);
      data_in = ~data_in;
      wait_stb(n0);
      check(n0 + j == PERIOD, "R5 current period unchanged", n0 + j, PERIOD);
      wait_stb(n1);
      check(n1 == e, {tag, " R6 corrected period"}, n1, e);
      wait_stb(n2);
      check(n2 == PERIOD, "R5 one-shot correction", n2, PERIOD);
      check(bit_out == data_in && bit_vld, "R9 captured bit", int'(bit_out), int'(data_in));
    end

    // R7: mid-symbol mode shifts the strobe by half a symbol
    wait_stb(n);
    mode_edge = 1'b0;
    wait_stb(n);
    check(n == HALF, "R7 mid-symbol offset", n, HALF);
    wait_stb(n);
    check(n == PERIOD, "R1 spacing in mode 0", n, PERIOD);
    check(bit_out == data_in, "R9 mid-symbol capture", int'(bit_out), int'(data_in));

    // R8: reset in mode 0 delays the first strobe by one period plus half
    @(negedge clk);
    rst_n = 1'b0;
    data_in = 1'b0;
    @(negedge clk);
    check(clk_stb == 1'b0 && bit_vld == 1'b0, "R8 reset outputs mode 0", int'(bit_vld), 0);
    rst_n = 1'b1;
    wait_stb(n);
    check(n == PERIOD + HALF, "R8 first strobe mode 0", n, PERIOD + HALF);

    finish_run();
  end
endmodule